// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a free-running watchdog counter driven by the bus clock. Software keeps it from expiring by writing a two-byte key, 0x55 and then 0xAA, to a service address. Other bus traffic may fall between the two key writes. If the counter runs out before a complete key arrives and the watchdog is enabled, the block sends a one-cycle timeout request to the chip's reset sequencer.

A control register sets the timeout length, enables the watchdog, and holds an enable bit for an external clock-failure detector. It also reports a sticky flag saying that the last reset came from the watchdog or from the clock detector.

The timeout is a fixed power-of-two prescale, 2^15 bus cycles by default, followed by a divide of 1, 4, 16 or 64 chosen by a two-bit mode field. Two reset inputs are used. The power-on/external reset clears everything. The internal system reset clears the control bits and holds the counter at zero, but it keeps the reset-cause flag.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset (`rst_n` low) the control register reads 0x00, `wdog_rst_req` is low and `clkmon_en` is low. A power-on reset also clears the reset-cause flag.
- R2: The control register at CTL_ADDR (0x1E) reads as {3'b000, flag, cme, cope, mode[1:0]}: flag at bit 4, clock-monitor enable at bit 3, watchdog enable at bit 2, mode at bits 1:0. A write stores bits 3..0 only. Bits 7..5 and bit 4 are unaffected by writes.
- R3: With mode m, a timeout occurs exactly 2^PRE_W * 4^m clock edges after the counter was last cleared. Mode resets to 00, which is the shortest period.
- R4: The counter runs whatever the value of cope, but `wdog_rst_req` can only pulse while cope is 1. With cope at 0 the flag is not set by timeouts.
- R5: A write of 0x55 to SVC_ADDR (0x1D) followed by a write of 0xAA to SVC_ADDR clears the prescaler and divider to zero on the edge that accepts the 0xAA. Reads, control writes and writes to other addresses between the two key writes do not disturb the sequence.
- R6: A write of 0xAA to SVC_ADDR that does not follow an armed 0x55 has no effect on the counter. A write of any value other than 0x55 or 0xAA to SVC_ADDR disarms a pending 0x55.
- R7: `wdog_rst_req` is high for exactly one cycle per timeout. The counter then restarts from zero, so an unserviced watchdog times out again one full period later.
- R8: Each timeout pulse sets the flag. A `clkmon_fail` pulse sets the flag only while cme is 1. A read of the control register clears the flag after returning its value. If a set and a clearing read fall in the same cycle, the set wins.
- R9: While `sys_rst` is high, cme, cope and mode are forced to 0, the counter is held at zero and no request is issued. The flag keeps its value.
- R10: A completed key sequence accepted on the same edge that would have ended the period suppresses that timeout, and a new full period starts.
- R11: `clkmon_en` always equals the stored cme bit and can be written at any time.
- R12: Reading SVC_ADDR, or any address other than CTL_ADDR, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on/external reset, active low, asynchronous |
| sys_rst | input | 1 | Internal system reset in progress, active high, synchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| clkmon_fail | input | 1 | Failure pulse from the clock-failure detector |
| clkmon_en | output | 1 | Clock-monitor enable to the detector |
| wdog_rst_req | output | 1 | One-cycle timeout request to the reset sequencer |

## Verification
The bench measures the timeout in clock edges from the accepting key write for every mode. An off-by-one prescale or a wrong divide would show up as a count that differs from 2^PRE_W * 4^m. It also checks the behaviour of a lone 0xAA and of a foreign value written after 0x55. A key decoder that ignored order or never disarmed would push the timeout back, and the pulse would arrive late.

The 0xAA write is placed on the very edge where the period ends, to confirm that the service wins. A design that let the timeout through would pulse 16 edges early. The bench drives a clearing read in the same cycle as a clock-failure pulse, holds `sys_rst` longer than a period, and confirms the flag survives it. A design that dropped the flag, or that kept counting during system reset, would give the wrong read value or an early pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Data path width of the register interface.
    localparam int BYTE_W = 8;

    // Width of the timeout divide select.
    localparam int MODE_W = 2;

    // Writable control bits: cme, cope and mode.
    localparam int CFG_W = MODE_W + 2;

    // Service key values, in the order they must arrive.
    localparam logic [BYTE_W-1:0] KEY_ARM  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_FIRE = 8'hAA;

    // Packed so that the bit order matches the register read layout.
    typedef struct packed {
        logic              flag;
        logic              cme;
        logic              cope;
        logic [MODE_W-1:0] mode;
    } wdog_ctl_t;

    localparam int CTL_W = $bits(wdog_ctl_t);
    localparam int PAD_W = BYTE_W - CTL_W;

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              key_wr,
    input  logic [BYTE_W-1:0] key_data,
    output logic              svc_hit
);

    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (sys_rst) begin
            st_d.armed = 1'b0;
        end else if (key_wr) begin
            unique case (key_data)
                KEY_ARM: begin
                    st_d.armed = 1'b1;
                end
                KEY_FIRE: begin
                    // Completes only when armed; always leaves the sequence idle.
                    hit        = st_q.armed;
                    st_d.armed = 1'b0;
                end
                default: begin
                    st_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Combinational so the counter clears on the accepting edge itself.
    assign svc_hit = hit;

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
    import wdog_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              svc_hit,
    input  logic              cope,
    input  logic [MODE_W-1:0] mode,
    output logic              tmo_req
);

    // Largest divide is 4^(2^MODE_W - 1); its counter needs this many bits.
    localparam int DIV_W = 2 * ((1 << MODE_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic             req;
    } tb_st_t;

    tb_st_t           st_d, st_q;
    logic [DIV_W-1:0] last_div;
    logic             pre_wrap;

    // Terminal divider value: 4^mode - 1, i.e. the low 2*mode bits set.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            last_div[i] = (i < 2 * int'(mode));
        end
    end

    assign pre_wrap = &st_q.pre;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (sys_rst || svc_hit) begin
            st_d.pre = '0;
            st_d.div = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
            if (pre_wrap) begin
                // >= keeps a shortened period from wrapping the long way round.
                if (st_q.div >= last_div) begin
                    st_d.div = '0;
                    st_d.req = cope;
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo_req = st_q.req;

endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [CFG_W-1:0] wr_bits,
    input  logic             tmo_seen,
    input  logic             clkmon_fail,
    output wdog_ctl_t        ctl
);

    wdog_ctl_t ctl_d, ctl_q;
    logic      flag_set;

    assign flag_set = tmo_seen | (clkmon_fail & ctl_q.cme);

    always_comb begin
        ctl_d = ctl_q;
        if (sys_rst) begin
            ctl_d.cme  = 1'b0;
            ctl_d.cope = 1'b0;
            ctl_d.mode = '0;
        end else if (ctl_wr) begin
            {ctl_d.cme, ctl_d.cope, ctl_d.mode} = wr_bits;
        end
        // The flag outlives system reset; a set beats a clearing read.
        if (flag_set) begin
            ctl_d.flag = 1'b1;
        end else if (ctl_rd) begin
            ctl_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int              PRE_W    = 15,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h1D,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              clkmon_fail,
    output logic              clkmon_en,
    output logic              wdog_rst_req
);

    logic      svc_sel, ctl_sel;
    logic      svc_wr, ctl_wr, ctl_rd;
    logic      svc_hit;
    logic      tmo_req;
    wdog_ctl_t ctl_q;

    assign svc_sel = (bus_addr == SVC_ADDR);
    assign ctl_sel = (bus_addr == CTL_ADDR);
    assign svc_wr  = bus_wr & svc_sel;
    assign ctl_wr  = bus_wr & ctl_sel;
    assign ctl_rd  = bus_rd & ctl_sel;

    wdog_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst  (sys_rst),
        .key_wr   (svc_wr),
        .key_data (bus_wdata),
        .svc_hit  (svc_hit)
    );

    wdog_timebase #(
        .PRE_W (PRE_W)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_rst (sys_rst),
        .svc_hit (svc_hit),
        .cope    (ctl_q.cope),
        .mode    (ctl_q.mode),
        .tmo_req (tmo_req)
    );

    wdog_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_rst     (sys_rst),
        .ctl_wr      (ctl_wr),
        .ctl_rd      (ctl_rd),
        .wr_bits     (bus_wdata[CFG_W-1:0]),
        .tmo_seen    (tmo_req),
        .clkmon_fail (clkmon_fail),
        .ctl         (ctl_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctl_sel) begin
            bus_rdata = {{PAD_W{1'b0}}, ctl_q};
        end
    end

    assign clkmon_en    = ctl_q.cme;
    assign wdog_rst_req = tmo_req;

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sys_rst,
    input logic              req,
    input logic              svc_hit,
    input logic              cope,
    input logic              flag,
    input logic              cme,
    input logic              clkmon_en,
    input logic [BYTE_W-1:0] rdata
);

    // R7: a request never lasts two cycles.
    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R4: a request implies the watchdog was enabled when it was raised.
    assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(cope));

    // R8: the flag is set once a request has been seen.
    assert_flag_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> flag);

    // R9: system reset leaves no request behind it.
    assert_sysrst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !req);

    // R10: an accepted service suppresses a request on the same edge.
    assert_svc_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hit |=> !req);

    // R2: the unused top bits always read as zero.
    assert_rdata_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BYTE_W-1:CTL_W] == '0);

    // R11: the enable output tracks the stored bit.
    assert_cme_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clkmon_en == cme);

endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst   (sys_rst),
    .req       (wdog_rst_req),
    .svc_hit   (svc_hit),
    .cope      (ctl_q.cope),
    .flag      (ctl_q.flag),
    .cme       (ctl_q.cme),
    .clkmon_en (clkmon_en),
    .rdata     (bus_rdata)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/100ps
module sim_keyed_wdog;

    localparam int   PRE_W = 4;
    localparam int   BASE  = 1 << PRE_W;
    localparam logic [7:0] SVC = 8'h1D;
    localparam logic [7:0] CTL = 8'h1E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       clkmon_fail = 1'b0;
    logic       clkmon_en;
    logic       wdog_rst_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    keyed_wdog #(.PRE_W(PRE_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_rst      (sys_rst),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .clkmon_fail  (clkmon_fail),
        .clkmon_en    (clkmon_en),
        .wdog_rst_req (wdog_rst_req)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Scoreboard monitor: compares each read against the queued expectation.
    always begin
        @(negedge clk);
        #1;
        if (bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty actual=%02h expected=none", bus_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s read actual=%02h expected=%02h", t, bus_rdata, e);
                end
            end
        end
    end

    // Watchdog on the bench itself.
    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic service();
        wr(SVC, 8'h55);
        wr(SVC, 8'hAA);
    endtask

    // Edges elapsed from t0 to the first visible request, or -1 on give-up.
    task automatic wait_req(input int t0, input int limit, output int el);
        int n;
        n = 0;
        el = -1;
        forever begin
            @(negedge clk);
            if (wdog_rst_req) begin
                el = cyc - t0;
                return;
            end
            n++;
            if (n > limit) return;
        end
    endtask

    initial begin
        int t0;
        int el;
        int highs;

        // R1: power-on reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", wdog_rst_req, 0);
        check("R1 clkmon_en after reset", clkmon_en, 0);
        rd(CTL, 8'h00, "R1");
        rd(SVC, 8'h00, "R12");
        rd(8'h40, 8'h00, "R12");

        // R2 / R11: write all ones, only bits 3..0 stick
        wr(CTL, 8'hFF);
        check("R11 clkmon_en follows write", clkmon_en, 1);
        rd(CTL, 8'h0F, "R2");

        // R3 / R7: mode 0, enabled
        wr(CTL, 8'h04);
        service();
        t0 = cyc;
        wait_req(t0, 4 * BASE, el);
        check("R3 mode0 period", el, BASE);
        t0 = cyc;
        @(negedge clk);
        check("R7 single-cycle pulse", wdog_rst_req, 0);
        wait_req(t0, 4 * BASE, el);
        check("R7 free-running repeat", el, BASE);
        rd(CTL, 8'h14, "R8");
        rd(CTL, 8'h04, "R8");

        // R3: longer modes
        for (int m = 1; m < 4; m++) begin
            wr(CTL, 8'(4 | m));
            service();
            t0 = cyc;
            wait_req(t0, 4 * (BASE << (2 * m)), el);
            check($sformatf("R3 mode%0d period", m), el, BASE << (2 * m));
        end

        // R5: activity between the key writes
        wr(CTL, 8'h05);
        service();
        wr(SVC, 8'h55);
        rd(CTL, 8'h15, "R5");
        rd(CTL, 8'h05, "R5");
        wr(8'h20, 8'hAA);
        wr(CTL, 8'h05);
        wr(SVC, 8'hAA);
        t0 = cyc;
        wait_req(t0, 4 * BASE * 4, el);
        check("R5 interleaved service", el, BASE * 4);

        // R6: lone 0xAA does nothing
        service();
        t0 = cyc;
        wr(SVC, 8'hAA);
        wait_req(t0, 4 * BASE * 4, el);
        check("R6 lone AA ignored", el, BASE * 4);

        // R6: foreign value disarms
        service();
        t0 = cyc;
        wr(SVC, 8'h55);
        wr(SVC, 8'h12);
        wr(SVC, 8'hAA);
        wait_req(t0, 4 * BASE * 4, el);
        check("R6 foreign value disarms", el, BASE * 4);

        // R10: service on the expiring edge
        wr(CTL, 8'h04);
        service();
        t0 = cyc;
        wr(SVC, 8'h55);
        while (cyc != t0 + BASE - 1) @(negedge clk);
        bus_wr = 1'b1; bus_addr = SVC; bus_wdata = 8'hAA;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 no pulse on service edge", wdog_rst_req, 0);
        wait_req(t0, 4 * BASE, el);
        check("R10 period restarts", el, 2 * BASE);

        // R4: disabled watchdog never requests
        wr(CTL, 8'h00);
        rd(CTL, 8'h10, "R4");
        highs = 0;
        for (int i = 0; i < 10 * BASE; i++) begin
            @(negedge clk);
            if (wdog_rst_req) highs++;
        end
        check("R4 no request with cope=0", highs, 0);
        rd(CTL, 8'h00, "R4");

        // R8 / R11: clock-monitor failure input
        @(negedge clk);
        clkmon_fail = 1'b1;
        @(negedge clk);
        clkmon_fail = 1'b0;
        rd(CTL, 8'h00, "R8");
        wr(CTL, 8'h08);
        check("R11 clkmon_en set", clkmon_en, 1);
        @(negedge clk);
        clkmon_fail = 1'b1;
        @(negedge clk);
        clkmon_fail = 1'b0;
        rd(CTL, 8'h18, "R8");
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = CTL; clkmon_fail = 1'b1;
        exp_q.push_back(8'h08);
        tag_q.push_back("R8");
        @(negedge clk);
        bus_rd = 1'b0; clkmon_fail = 1'b0;
        rd(CTL, 8'h18, "R8");

        // R9: system reset keeps flag, clears bits, holds counter
        wr(CTL, 8'h0D);
        @(negedge clk);
        clkmon_fail = 1'b1;
        @(negedge clk);
        clkmon_fail = 1'b0;
        sys_rst = 1'b1;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdog_rst_req) highs++;
        end
        sys_rst = 1'b0;
        t0 = cyc;
        check("R9 no request during sys_rst", highs, 0);
        check("R9 clkmon_en cleared", clkmon_en, 0);
        rd(CTL, 8'h10, "R9");
        wr(CTL, 8'h04);
        wait_req(t0, 4 * BASE, el);
        check("R9 counter held at zero", el, BASE);

        // R1: power-on reset clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(CTL, 8'h00, "R1");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule